// File: doc/BRIEF.md
# Shadowed nonvolatile RAM controller

A byte-wide memory of 512 locations built from a fast volatile array in which every byte has a nonvolatile twin. Hosts read and write the volatile array through active-low chip, output and write enables, with a 9-bit address and a data bus split into input, output and output-enable. A fourth active-low control, the nonvolatile enable, turns a bus cycle into a whole-array transfer. A store copies volatile to nonvolatile. A recall copies nonvolatile to volatile.

Each transfer runs for a fixed, parameterised number of clock cycles, copying one byte per cycle and then holding busy until its time budget is used up. Leaving reset models power-up and always starts a recall. When automatic store is enabled, a rising supply-low flag starts a store without a host command. A pull-low status output follows the supply-low flag, so that several such outputs can share one interrupt line.

Top module: `shadow_nvram_ctrl`

## Requirements
- R1: When idle, a write cycle stores `data_i` at `addr_i` on the clock edge. A write cycle is ce_ni=0, we_ni=0 and ne_ni=1. A read cycle is ce_ni=0, oe_ni=0, we_ni=1 and ne_ni=1. In a read cycle `data_oe_o`=1 and `data_o` shows the byte at `addr_i` in the same cycle.
- R2: With ce_ni=1 no byte is written, whatever the other controls are.
- R3: `data_oe_o` is 0 whenever ce_ni=1, oe_ni=1, we_ni=0 or ne_ni=0.
- R4: After rst_ni rises, `busy_o` stays 1 for exactly RECALL_CYCLES cycles. After that, every volatile byte equals its nonvolatile twin.
- R5: A host store starts on the first cycle in which ce_ni=0, ne_ni=0, we_ni=0 and oe_ni=1 hold while the block is idle. `busy_o` rises on the next cycle and stays 1 for exactly STORE_CYCLES cycles. Afterwards the nonvolatile array holds the volatile contents seen at the start.
- R6: A host recall starts on the first cycle in which ce_ni=0, ne_ni=0, oe_ni=0 and we_ni=1 hold while the block is idle. It keeps `busy_o` at 1 for exactly RECALL_CYCLES cycles. Afterwards every volatile byte equals its nonvolatile twin.
- R7: A rising `supply_low_i` while `autostore_en_i`=1, oe_ni=1 and the block is idle starts a store of STORE_CYCLES cycles. The same rise with `autostore_en_i`=0 starts nothing.
- R8: `sag_pull_o`=1 (pulling the shared line low) exactly while `supply_low_i`=1.
- R9: While oe_ni=0, no store starts, neither from the host nor from the supply-low flag.
- R10: While `busy_o`=1, host writes are ignored and `data_oe_o`=0. Store or recall triggers seen while busy are dropped and do not run later.
- R11: The nonvolatile contents survive a reset pulse. The recall after the pulse restores them to the volatile array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, models power-up |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| ne_ni | input | 1 | Nonvolatile enable, active low |
| addr_i | input | 9 | Byte address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | 1 = data bus driven, 0 = high impedance |
| supply_low_i | input | 1 | Supply below the auto-store threshold |
| autostore_en_i | input | 1 | Enables the store on a supply-low rise |
| busy_o | output | 1 | A store or recall is running |
| sag_pull_o | output | 1 | 1 = status line pulled low |

## Verification
The assertions check the cycle-level rules on every cycle. The bus is released under each disabling control and while busy. Busy holds for the full recall budget after reset. Every busy run lasts exactly one of the two budgets. A supply-low rise with auto-store enabled starts a transfer, and output enable low keeps the block idle. Only the bench can show that the data moved. That means whole-array contents after the power-up, host and supply-triggered transfers, writes lost while busy, and nonvolatile contents outliving a reset pulse. The bench checks these by reading back every address against its own models of both arrays.

// File: rtl/shadow_nvram_pkg.sv
package shadow_nvram_pkg;
  typedef enum logic [1:0] {XFER_IDLE, XFER_RECALL, XFER_STORE} xfer_e;
endpackage

// File: rtl/nvr_mem.sv
module nvr_mem #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // cleared array at start of simulation
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/nvr_seq.sv
module nvr_seq
  import shadow_nvram_pkg::*;
#(
  parameter int ADDR_W        = 9,
  parameter int RECALL_CYCLES = 520,
  parameter int STORE_CYCLES  = 1100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_recall_i,
  input  logic              start_store_i,
  output xfer_e             op_o,
  output logic              copy_o,
  output logic [ADDR_W-1:0] idx_o,
  output logic              busy_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXC  = (RECALL_CYCLES > STORE_CYCLES) ? RECALL_CYCLES : STORE_CYCLES;
  localparam int CW0   = $clog2(MAXC);
  localparam int CNT_W = (CW0 > ADDR_W) ? CW0 : ADDR_W + 1;
  localparam logic [CNT_W-1:0] RC_LAST = CNT_W'(RECALL_CYCLES - 1);
  localparam logic [CNT_W-1:0] SC_LAST = CNT_W'(STORE_CYCLES - 1);

  xfer_e            op_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last = (op_q == XFER_STORE) ? (cnt_q == SC_LAST) : (cnt_q == RC_LAST);

  // reset = power-up: recall begins immediately
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= XFER_RECALL;
      cnt_q <= '0;
    end else if (op_q == XFER_IDLE) begin
      cnt_q <= '0;
      if (start_store_i)       op_q <= XFER_STORE;
      else if (start_recall_i) op_q <= XFER_RECALL;
    end else if (last) begin
      op_q  <= XFER_IDLE;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign op_o   = op_q;
  assign busy_o = (op_q != XFER_IDLE);
  assign copy_o = busy_o && (cnt_q < CNT_W'(DEPTH));
  assign idx_o  = cnt_q[ADDR_W-1:0];
endmodule

// File: rtl/shadow_nvram_ctrl.sv
module shadow_nvram_ctrl
  import shadow_nvram_pkg::*;
#(
  parameter int ADDR_W        = 9,
  parameter int DATA_W        = 8,
  parameter int RECALL_CYCLES = 520,
  parameter int STORE_CYCLES  = 1100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              ne_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic              supply_low_i,
  input  logic              autostore_en_i,
  output logic              busy_o,
  output logic              sag_pull_o
);
  xfer_e             op;
  logic              copy, busy;
  logic [ADDR_W-1:0] idx;
  logic              store_req, recall_req, store_req_q, recall_req_q, supply_q;
  logic              start_store, start_recall, host_wr;
  logic              vol_we, nv_we;
  logic [ADDR_W-1:0] vol_waddr, vol_raddr;
  logic [DATA_W-1:0] vol_wdata, vol_rdata, nv_rdata;

  assign store_req  = !ce_ni && !ne_ni && !we_ni &&  oe_ni;
  assign recall_req = !ce_ni && !ne_ni && !oe_ni &&  we_ni;

  // edge detect: a held command or held supply flag fires once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_req_q  <= 1'b0;
      recall_req_q <= 1'b0;
      supply_q     <= 1'b0;
    end else begin
      store_req_q  <= store_req;
      recall_req_q <= recall_req;
      supply_q     <= supply_low_i;
    end
  end

  assign start_store  = !busy && oe_ni &&
                        ((store_req && !store_req_q) ||
                         (autostore_en_i && supply_low_i && !supply_q));
  assign start_recall = !busy && recall_req && !recall_req_q;

  nvr_seq #(
    .ADDR_W(ADDR_W), .RECALL_CYCLES(RECALL_CYCLES), .STORE_CYCLES(STORE_CYCLES)
  ) u_seq (
    .clk_i, .rst_ni,
    .start_recall_i(start_recall), .start_store_i(start_store),
    .op_o(op), .copy_o(copy), .idx_o(idx), .busy_o(busy)
  );

  assign host_wr   = !ce_ni && !we_ni && ne_ni && !busy;
  assign vol_we    = host_wr || (copy && op == XFER_RECALL);
  assign vol_waddr = busy ? idx : addr_i;
  assign vol_wdata = busy ? nv_rdata : data_i;
  assign vol_raddr = busy ? idx : addr_i;
  assign nv_we     = copy && op == XFER_STORE;

  nvr_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_vol (
    .clk_i, .we_i(vol_we), .waddr_i(vol_waddr), .wdata_i(vol_wdata),
    .raddr_i(vol_raddr), .rdata_o(vol_rdata)
  );

  nvr_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_nv (
    .clk_i, .we_i(nv_we), .waddr_i(idx), .wdata_i(vol_rdata),
    .raddr_i(idx), .rdata_o(nv_rdata)
  );

  assign data_o     = vol_rdata;
  assign data_oe_o  = !ce_ni && !oe_ni && we_ni && ne_ni && !busy;
  assign busy_o     = busy;
  assign sag_pull_o = supply_low_i;
endmodule

// File: rtl/shadow_nvram_chk.sv
module shadow_nvram_chk #(
  parameter int RECALL_CYCLES = 520,
  parameter int STORE_CYCLES  = 1100
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ce_ni,
  input logic oe_ni,
  input logic we_ni,
  input logic ne_ni,
  input logic data_oe_o,
  input logic supply_low_i,
  input logic autostore_en_i,
  input logic busy_o
);
  logic [31:0] run_q, up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      up_q  <= '0;
    end else begin
      run_q <= busy_o ? run_q + 1 : '0;
      if (up_q < 32'(RECALL_CYCLES)) up_q <= up_q + 1;
    end
  end

  AST_BUS_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni || !we_ni || !ne_ni) |-> !data_oe_o); // R3
  AST_BUSY_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !data_oe_o); // R10
  AST_POWERUP_RECALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q < 32'(RECALL_CYCLES)) |-> busy_o); // R4
  AST_BUSY_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == 32'(RECALL_CYCLES) || run_q == 32'(STORE_CYCLES))); // R5
  AST_AUTOSTORE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(supply_low_i) && autostore_en_i && !busy_o && oe_ni) |=> busy_o); // R7
  AST_OE_BLOCKS_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !oe_ni && !(!ce_ni && !ne_ni && we_ni)) |=> !busy_o); // R9
endmodule

bind shadow_nvram_ctrl shadow_nvram_chk #(
  .RECALL_CYCLES(RECALL_CYCLES), .STORE_CYCLES(STORE_CYCLES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni),
  .ne_ni(ne_ni), .data_oe_o(data_oe_o), .supply_low_i(supply_low_i),
  .autostore_en_i(autostore_en_i), .busy_o(busy_o)
);

// File: tb/shadow_nvram_ctrl_tb_top.sv
module shadow_nvram_ctrl_tb_top;
  localparam int AW = 9, DW = 8, DEPTH = 512, RC = 520, SC = 1100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n, oe_n, we_n, ne_n, supply_low, as_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic dout_en, busy, sag;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] vm [DEPTH];
  logic [DW-1:0] nm [DEPTH];

  always #5 clk = ~clk;

  shadow_nvram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RECALL_CYCLES(RC), .STORE_CYCLES(SC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n), .ne_ni(ne_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(dout_en),
    .supply_low_i(supply_low), .autostore_en_i(as_en), .busy_o(busy), .sag_pull_o(sag)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic bus_on(logic c, logic o, logic w, logic n);
    return !c && !o && w && n;
  endfunction

  task automatic idle();
    ce_n = 1; oe_n = 1; we_n = 1; ne_n = 1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, logic ce);
    ce_n = ce; we_n = 0; oe_n = 1; ne_n = 1; addr = a; din = d;
    @(negedge clk); idle();
  endtask

  task automatic rd(logic [AW-1:0] a, logic [DW-1:0] exp, string req);
    ce_n = 0; oe_n = 0; we_n = 1; ne_n = 1; addr = a;
    #1;
    chk({req, " bus enable"}, 32'(dout_en), 32'd1);
    chk({req, " read data"}, 32'(dout), 32'(exp));
    @(negedge clk); idle();
  endtask

  task automatic wait_busy(int pre, int exp, string req);
    int n = pre;
    while (busy && n < 5000) begin n++; @(negedge clk); end
    chk({req, " busy length"}, 32'(n), 32'(exp));
  endtask

  task automatic read_all(string req);
    for (int a = 0; a < DEPTH; a++) rd(AW'(a), vm[a], req);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [AW-1:0] x;
    void'($urandom(32'h5eed));
    idle(); supply_low = 0; as_en = 0; addr = '0; din = '0;
    #1;
    // preload the nonvolatile array through the hierarchy
    for (int i = 0; i < DEPTH; i++) begin
      nm[i] = DW'($urandom);
      dut_i.u_nv.mem[i] = nm[i];
    end
    @(negedge clk); @(negedge clk);
    chk("R4 busy in reset", 32'(busy), 32'd1);
    chk("R3 bus off in reset", 32'(dout_en), 32'd0);

    // R4 power-up recall
    rst_n = 1;
    wait_busy(0, RC, "R4");
    vm = nm;
    read_all("R4");

    // R1 / R2 random host traffic
    for (int i = 0; i < 400; i++) begin
      int op = int'($urandom % 4);
      logic [AW-1:0] a = AW'($urandom);
      logic [DW-1:0] d = DW'($urandom);
      if (op < 2) begin wr(a, d, 0); vm[a] = d; end
      else if (op == 2) rd(a, vm[a], "R1");
      else begin wr(a, ~vm[a], 1); rd(a, vm[a], "R2 write with ce high"); end
    end

    // R3 control combinations that start no transfer
    for (int i = 0; i < 60; i++) begin
      logic c = 1'($urandom), o = 1'($urandom), w = 1'($urandom), n = 1'($urandom);
      logic [AW-1:0] a = AW'($urandom);
      if (!c && !n && (w != o)) continue;
      ce_n = c; oe_n = o; we_n = w; ne_n = n; addr = a; din = DW'($urandom);
      #1;
      chk("R3 bus enable", 32'(dout_en), 32'(bus_on(c, o, w, n)));
      if (bus_on(c, o, w, n)) chk("R1 read data", 32'(dout), 32'(vm[a]));
      if (!c && !w && n) vm[a] = din;
      @(negedge clk); idle();
      chk("R9 no transfer started", 32'(busy), 32'd0);
    end

    // R9 oe low blocks store
    ce_n = 0; ne_n = 0; we_n = 0; oe_n = 0;
    @(negedge clk); idle();
    chk("R9 host store blocked", 32'(busy), 32'd0);
    as_en = 1; oe_n = 0; supply_low = 1;
    @(negedge clk);
    chk("R9 auto store blocked", 32'(busy), 32'd0);
    chk("R8 pull while low", 32'(sag), 32'd1);
    supply_low = 0; idle(); as_en = 0;
    @(negedge clk);
    chk("R8 release", 32'(sag), 32'd0);

    // R5 host store with R10 traffic while busy
    ce_n = 0; ne_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk); idle();
    chk("R5 store started", 32'(busy), 32'd1);
    nm = vm;
    x = AW'($urandom);
    wr(x, ~vm[x], 0);
    ce_n = 0; oe_n = 0; we_n = 1; ne_n = 1; addr = x;
    #1 chk("R10 no drive while busy", 32'(dout_en), 32'd0);
    @(negedge clk); idle();
    ce_n = 0; ne_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk); idle();
    wait_busy(3, SC, "R5");
    @(negedge clk);
    chk("R10 dropped trigger", 32'(busy), 32'd0);
    rd(x, vm[x], "R10 write ignored");

    // R6 overwrite volatile then recall
    for (int a = 0; a < DEPTH; a++) begin
      logic [DW-1:0] d = DW'($urandom);
      wr(AW'(a), d, 0); vm[a] = d;
    end
    ce_n = 0; ne_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk); idle();
    wait_busy(0, RC, "R6");
    vm = nm;
    read_all("R6");

    // R7 auto store
    for (int i = 0; i < 20; i++) begin
      logic [AW-1:0] a = AW'($urandom);
      logic [DW-1:0] d = DW'($urandom);
      wr(a, d, 0); vm[a] = d;
    end
    as_en = 1; supply_low = 1;
    @(negedge clk);
    chk("R8 pull while low", 32'(sag), 32'd1);
    chk("R7 auto store started", 32'(busy), 32'd1);
    nm = vm;
    wait_busy(0, SC, "R7");
    supply_low = 0;
    @(negedge clk);
    chk("R8 release", 32'(sag), 32'd0);
    as_en = 0; supply_low = 1;
    @(negedge clk); @(negedge clk);
    chk("R7 disabled auto store", 32'(busy), 32'd0);
    supply_low = 0;

    // R11 power cycle keeps nonvolatile contents
    for (int i = 0; i < 30; i++) wr(AW'($urandom), DW'($urandom), 0);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    wait_busy(0, RC, "R11");
    vm = nm;
    read_all("R11");

    summary();
    $finish;
  end
endmodule